// File: doc/BRIEF.md
# Maskable Interrupt Status and Enable Unit

This block gathers interrupt requests for one CPU and folds them onto a single level-sensitive IRQ line. Three of the sources are internal to the block: a free-running periodic timer, a printer request and a keyboard request. The others come from outside and are taken as levels: a floppy controller, a set of sound-chip interrupt lines and a mouse line. Each internal source, and the floppy controller, has its own enable bit.

Software reaches the block over a simple peripheral register bus. It writes an enable byte at one offset. It reads an active-low status byte at another offset. Reading the status byte acknowledges the timer and the printer. The keyboard bit instead follows the live keyboard level, and it stays low for as long as the keyboard is requesting and enabled. All external controllers share one status bit. Software that sees that bit low must poll those controllers directly.

Top module: `irq_status_unit`

## Requirements
- R1: A write to offset 0x02 loads the enables from the data byte: bit 4 floppy controller, bit 2 timer, bit 1 printer, bit 0 keyboard; a 1 enables the source and the other data bits are ignored.
- R2: A read of offset 0x03 puts the status byte on `bus_rdata` after the clock edge that samples the read. Bits 7..4 are 1. Bit 2 (timer), bit 1 (printer) and bit 0 (keyboard) are each 0 while that source is pending and enabled, and 1 otherwise. The byte holds until the next read.
- R3: Status bit 3 is 0 when the floppy line or any sound line is high, whatever the enables, and 1 otherwise.
- R4: A status read clears the timer and printer pending states at the edge that samples it; the keyboard bit is not affected by the read.
- R5: A timer or printer request becomes pending only while its enable is 1; writing its enable to 0 clears its pending state at that same edge.
- R6: The internal timer raises a request once every `PERIOD_CLKS` clocks; the first one is taken at the `PERIOD_CLKS`-th edge after reset is released.
- R7: While reset is high, all enables and pending states are cleared, the timer restarts and `bus_rdata` is 0xFF.
- R8: `cpu_irq` is high exactly when the timer or printer is pending, or the keyboard line and its enable are both high, or the floppy line and its enable are both high, or any sound line or the mouse line is high.
- R9: When a new timer or printer request arrives in the same cycle as a status read, the request stays pending.
- R10: Reads of any offset other than 0x03 return 0xFF and acknowledge nothing; writes to any offset other than 0x02 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| prn_req | input | 1 | Printer request level |
| kbd_req | input | 1 | Keyboard request level |
| fdc_irq | input | 1 | Floppy controller interrupt level |
| snd_irq | input | NUM_SND | Sound-chip interrupt levels |
| mouse_irq | input | 1 | Mouse interrupt level |
| cpu_irq | output | 1 | Level IRQ to the CPU |

## Verification
The hardest case to reach is a timer expiry that lands on the same edge as a status read, or on the same edge as an enable write. Coincidences like these decide whether an event is lost or a stale one survives. The bench shortens the timer period to a few dozen clocks. It then runs long stretches of pseudo-random reads and writes spread over the status offset, the enable offset and an unused offset. Its reference model is checked every cycle, so such collisions happen many times over without any aiming. Directed passes come first. They cover acknowledge, masking and the shared external bit one at a time.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

    localparam int unsigned OFS_ENABLE = 2;
    localparam int unsigned OFS_STATUS = 3;

    localparam int unsigned BIT_FDC = 4;
    localparam int unsigned BIT_EXT = 3;
    localparam int unsigned BIT_TMR = 2;
    localparam int unsigned BIT_PRN = 1;
    localparam int unsigned BIT_KBD = 0;

    typedef struct packed {
        logic fdc;
        logic tmr;
        logic prn;
        logic kbd;
    } irq_enable_t;

    typedef struct packed {
        logic ext;
        logic tmr;
        logic prn;
        logic kbd;
    } irq_flags_t;

    function automatic irq_enable_t decode_enable(input logic [7:0] data);
        irq_enable_t e;
        e.fdc = data[BIT_FDC];
        e.tmr = data[BIT_TMR];
        e.prn = data[BIT_PRN];
        e.kbd = data[BIT_KBD];
        return e;
    endfunction

    function automatic logic [7:0] encode_status(input irq_flags_t f);
        logic [7:0] s;
        s          = 8'hFF;
        s[BIT_EXT] = ~f.ext;
        s[BIT_TMR] = ~f.tmr;
        s[BIT_PRN] = ~f.prn;
        s[BIT_KBD] = ~f.kbd;
        return s;
    endfunction

endpackage

// File: rtl/irq_period_timer.sv
module irq_period_timer #(
    parameter int unsigned PERIOD_CLKS = 203500
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CNT_W = $clog2(PERIOD_CLKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CLKS - 1);

    logic [CNT_W-1:0] count_q;

    assign tick = (count_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/irq_pend_cell.sv
module irq_pend_cell (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic set,
    input  logic ack,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else begin
            pend <= enable & (set | (pend & ~ack));
        end
    end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned NUM_SND     = 3,
    parameter int unsigned PERIOD_CLKS = 203500
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    input  logic               prn_req,
    input  logic               kbd_req,
    input  logic               fdc_irq,
    input  logic [NUM_SND-1:0] snd_irq,
    input  logic               mouse_irq,
    output logic               cpu_irq
);
    import irq_unit_pkg::*;

    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

    irq_enable_t en_q;
    irq_enable_t en_nx;
    irq_flags_t  flags;
    logic        wr_enable;
    logic        rd_status;
    logic        tmr_tick;
    logic        tmr_pend;
    logic        prn_pend;
    logic        kbd_live;
    logic        ext_any;

    assign wr_enable = bus_wr && (bus_addr == A_ENABLE);
    assign rd_status = bus_rd && (bus_addr == A_STATUS);
    assign en_nx     = wr_enable ? decode_enable(bus_wdata) : en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            en_q <= en_nx;
        end
    end

    irq_period_timer #(
        .PERIOD_CLKS(PERIOD_CLKS)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tmr_tick)
    );

    irq_pend_cell u_tmr_cell (
        .clk    (clk),
        .rst    (rst),
        .enable (en_nx.tmr),
        .set    (tmr_tick),
        .ack    (rd_status),
        .pend   (tmr_pend)
    );

    irq_pend_cell u_prn_cell (
        .clk    (clk),
        .rst    (rst),
        .enable (en_nx.prn),
        .set    (prn_req),
        .ack    (rd_status),
        .pend   (prn_pend)
    );

    assign kbd_live = kbd_req & en_q.kbd;
    assign ext_any  = fdc_irq | (|snd_irq);

    always_comb begin
        flags.ext = ext_any;
        flags.tmr = tmr_pend;
        flags.prn = prn_pend;
        flags.kbd = kbd_live;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= 8'hFF;
        end else if (rd_status) begin
            bus_rdata <= encode_status(flags);
        end else if (bus_rd) begin
            bus_rdata <= 8'hFF;
        end
    end

    assign cpu_irq = tmr_pend | prn_pend | kbd_live | (fdc_irq & en_q.fdc)
                   | (|snd_irq) | mouse_irq;
endmodule

// File: rtl/irq_status_checker.sv
module irq_status_checker #(
    parameter int unsigned NUM_SND = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               rd_status,
    input logic               wr_enable,
    input logic [7:0]         bus_rdata,
    input logic               tmr_tick,
    input logic               tmr_pend,
    input logic               tmr_en,
    input logic [NUM_SND-1:0] snd_irq,
    input logic               mouse_irq,
    input logic               cpu_irq
);
    assert_upper_nibble_R2: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[7:4] == 4'hF);

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_status && !tmr_tick) |=> !tmr_pend);

    assert_masked_no_pend_R5: assert property (@(posedge clk) disable iff (rst)
        !tmr_en |-> !tmr_pend);

    assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        tmr_tick |=> !tmr_tick);

    assert_ext_drives_irq_R8: assert property (@(posedge clk) disable iff (rst)
        ((|snd_irq) || mouse_irq) |-> cpu_irq);

    assert_set_beats_ack_R9: assert property (@(posedge clk) disable iff (rst)
        (tmr_tick && tmr_en && !wr_enable) |=> tmr_pend);
endmodule

bind irq_status_unit irq_status_checker #(
    .NUM_SND(NUM_SND)
) u_irq_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_status (rd_status),
    .wr_enable (wr_enable),
    .bus_rdata (bus_rdata),
    .tmr_tick  (tmr_tick),
    .tmr_pend  (tmr_pend),
    .tmr_en    (en_q.tmr),
    .snd_irq   (snd_irq),
    .mouse_irq (mouse_irq),
    .cpu_irq   (cpu_irq)
);

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
    localparam int ADDR_W = 8;
    localparam int NSND   = 3;
    localparam int PER    = 37;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic              prn_req = 1'b0;
    logic              kbd_req = 1'b0;
    logic              fdc_irq = 1'b0;
    logic [NSND-1:0]   snd_irq = '0;
    logic              mouse_irq = 1'b0;
    logic              cpu_irq;

    always #5 clk = ~clk;

    irq_status_unit #(
        .ADDR_W(ADDR_W), .NUM_SND(NSND), .PERIOD_CLKS(PER)
    ) i_irq_status_unit (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .prn_req(prn_req), .kbd_req(kbd_req), .fdc_irq(fdc_irq),
        .snd_irq(snd_irq), .mouse_irq(mouse_irq), .cpu_irq(cpu_irq)
    );

    // reference model state
    int   m_cnt = 0;
    bit   m_ef, m_et, m_ep, m_ek;
    bit   m_tp, m_pp;
    int   m_rd = 255;
    bit   started = 0;
    int   vectors = 0;
    int   errors = 0;
    bit   finished = 0;
    string tag = "R7";

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_cnt = 0; m_ef = 0; m_et = 0; m_ep = 0; m_ek = 0;
            m_tp = 0; m_pp = 0; m_rd = 255;
        end else begin
            bit tick, rdst, ext;
            int st;
            tick = (m_cnt == PER - 1);
            m_cnt = tick ? 0 : m_cnt + 1;
            ext  = fdc_irq || (snd_irq != 0);
            rdst = bus_rd && (bus_addr == 3);
            st = 240 + (ext ? 0 : 8) + (m_tp ? 0 : 4) + (m_pp ? 0 : 2)
               + ((kbd_req && m_ek) ? 0 : 1);
            if (rdst) m_rd = st;
            else if (bus_rd) m_rd = 255;
            if (bus_wr && bus_addr == 2) begin
                m_ef = bus_wdata[4]; m_et = bus_wdata[2];
                m_ep = bus_wdata[1]; m_ek = bus_wdata[0];
            end
            m_tp = m_et && (tick || (m_tp && !rdst));
            m_pp = m_ep && (prn_req || (m_pp && !rdst));
        end
    end

    always @(negedge clk) begin
        #2;
        if (started && !finished) begin
            bit exp_irq;
            exp_irq = m_tp || m_pp || (kbd_req && m_ek) || (fdc_irq && m_ef)
                    || (snd_irq != 0) || mouse_irq;
            vectors++;
            if (bus_rdata !== 8'(m_rd)) begin
                errors++;
                $display("FAIL %s rdata actual=%02h expected=%02h t=%0t",
                         tag, bus_rdata, 8'(m_rd), $time);
            end
            vectors++;
            if (cpu_irq !== exp_irq) begin
                errors++;
                $display("FAIL %s,R8 cpu_irq actual=%0b expected=%0b t=%0t",
                         tag, cpu_irq, exp_irq, $time);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_wr = 1; bus_addr = 8'(a); bus_wdata = 8'(d);
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input int a);
        @(negedge clk);
        bus_rd = 1; bus_addr = 8'(a);
        @(negedge clk);
        bus_rd = 0;
    endtask

    function automatic logic [15:0] lfsr_step(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    initial begin
        logic [15:0] lf;
        tag = "R7"; idle(3); rst = 0; rd(3); idle(2);
        // R6 timer: enable and wait past one period, then acknowledge
        tag = "R6"; wr(2, 8'h04); idle(PER + 3);
        tag = "R4"; rd(3); rd(3); wr(2, 8'h00); idle(2);
        // R1 keyboard enable and R4 read does not clear it
        tag = "R1"; kbd_req = 1; idle(3); wr(2, 8'h01); idle(2);
        tag = "R4"; rd(3); rd(3); kbd_req = 0; idle(2);
        // R5 printer masked then enabled
        tag = "R5"; prn_req = 1; idle(2); prn_req = 0; rd(3);
        wr(2, 8'h02); prn_req = 1; @(negedge clk); prn_req = 0; idle(2);
        tag = "R2"; rd(3); rd(3);
        tag = "R5"; prn_req = 1; @(negedge clk); prn_req = 0;
        wr(2, 8'h00); rd(3);
        // R3 external sources
        tag = "R3"; fdc_irq = 1; rd(3); wr(2, 8'h10); idle(2); fdc_irq = 0;
        snd_irq = 3'b100; rd(3); snd_irq = 0; mouse_irq = 1; rd(3); mouse_irq = 0;
        // R10 other offsets
        tag = "R10"; wr(5, 8'hFF); wr(2, 8'hEB); wr(7, 8'h00); idle(PER + 2);
        rd(2); rd(5); rd(3);
        // R9 and mixed traffic
        tag = "R9,R2,R5";
        lf = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            lf = lfsr_step(lf);
            bus_rd = lf[0] & lf[3];
            bus_wr = lf[5] & lf[6] & lf[1];
            bus_addr = lf[8] ? 8'd3 : (lf[9] ? 8'd2 : 8'd5);
            bus_wdata = lf[15:8];
            prn_req = lf[11] & lf[12] & lf[2];
            if (lf[4] & lf[7] & lf[10]) kbd_req = ~kbd_req;
            if (lf[13] & lf[14] & lf[2] & lf[0]) fdc_irq = ~fdc_irq;
            if (lf[12] & lf[9] & lf[1] & lf[6]) snd_irq = lf[15:13];
            if (lf[3] & lf[11] & lf[14] & lf[5]) mouse_irq = ~mouse_irq;
        end
        bus_rd = 0; bus_wr = 0;
        tag = "R7"; rst = 1; idle(2); rst = 0; idle(2);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule